// File: doc/BRIEF.md
# Serial Configuration Chain Loader with Readback Check

This block loads the configuration of an external front-end chip whose settings sit in one long shift-register chain. That chain cannot be read directly. A local image of the chain is kept in a bank of byte-wide registers, which a host fills through a simple write port. On a start command the block shifts the whole image into the chain twice over a four-wire serial link made of an active-low select, a serial clock, data out and data in. During the second pass it compares each bit coming back from the far end of the chain with the bit it is sending at that moment. This is a valid check because the first pass has already pushed the image through the chain. At the end it reports completion, a sticky error flag and the number of disagreeing bits.

The same four wires also carry two reset actions to the external chip. Each one is encoded as a combination of pin levels held for a fixed number of system clocks. A soft reset drives select active with the serial clock high. A hard reset drives select inactive with data out high. Loads and resets run one at a time. A request that arrives while the block is occupied is dropped.

Top module: `cfg_chain_loader`

## Requirements
- R1: A write stores `wr_data_i` into image register `wr_addr_i`. The chain stream starts with register 0 and ends with register NUM_REGS-1, and each register is sent most significant bit first (MSB_FIRST=1).
- R2: A start accepted in idle sets `busy_o` from the next cycle. `cs_n_o` stays low for exactly 2·NUM_REGS·REG_W·SCLK_DIV cycles, with exactly 2·NUM_REGS·REG_W rising edges of `sclk_o`. The serial clock is low for the first SCLK_DIV/2 cycles of each bit and high for the rest.
- R3: `sdo_o` changes only together with a falling edge of `sclk_o`, or when a load begins or ends. It is steady across every rising edge.
- R4: After a load the external chain holds the image, with register 0's first bit at the far end.
- R5: During the second pass `sdi_i` is sampled on each rising edge and compared with `sdo_o`. `mismatch_o` equals the number of disagreeing bits, from 0 up to the full chain length. `err_o` is 1 exactly when that count is non-zero. No comparison is counted during the first pass.
- R6: `done_o` and `err_o` are set at the end of a load and keep their values until the next accepted start. At that start both are cleared, along with `mismatch_o`. Reset actions leave them unchanged.
- R7: A start, soft or hard reset request that arrives while `busy_o` is 1 is ignored. No second load follows.
- R8: A soft reset drives `cs_n_o`=0, `sclk_o`=1, `sdo_o`=0 for exactly RST_HOLD cycles, starting the cycle after the request, and then returns to idle.
- R9: A hard reset drives `cs_n_o`=1, `sclk_o`=0, `sdo_o`=1 for exactly RST_HOLD cycles, starting the cycle after the request, and then returns to idle.
- R10: When several requests arrive in the same idle cycle, hard reset wins over soft reset, and soft reset wins over start. The losing requests are dropped.
- R11: After reset and whenever idle: `cs_n_o`=1, `sclk_o`=0, `sdo_o`=0. After reset `busy_o`, `done_o`, `err_o` and `mismatch_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Image register write strobe |
| wr_addr_i | input | $clog2(NUM_REGS) | Image register index |
| wr_data_i | input | REG_W | Image register write data |
| start_i | input | 1 | Start a double-pass load |
| soft_rst_req_i | input | 1 | Request a soft reset action |
| hard_rst_req_i | input | 1 | Request a hard reset action |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, system clock / SCLK_DIV |
| sdo_o | output | 1 | Serial data toward the chain |
| sdi_i | input | 1 | Serial data returning from the chain end |
| busy_o | output | 1 | A load or reset action is running |
| done_o | output | 1 | A load has completed (sticky) |
| err_o | output | 1 | Readback disagreed (sticky) |
| mismatch_o | output | $clog2(NUM_REGS·REG_W+1) | Count of disagreeing bits in the last load |

## Verification
Two kinds of collision can happen in a single cycle. One is several requests in an idle cycle: start together with a soft or hard reset, or all three at once. The other is a start or reset request while a load is running. The bench raises all three request lines in the same idle cycle, then soft reset and start together. For each case it checks that the pin pattern is that of the winning reset for exactly the hold length, and that no serial clock edge and no completion follow. It also pulses start in the middle of a load. It then checks that the serial clock edge count and the select-low time match a single load, and that the block stays idle afterwards.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_SOFT  = 2'd2,
      ST_HARD  = 2'd3
   } ld_state_t;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cfg_image_regs.sv
module cfg_image_regs #(
   parameter int NUM_REGS  = 16,
   parameter int REG_W     = 8,
   parameter bit MSB_FIRST = 1'b1,
   parameter int AW        = 4,
   parameter int CHAIN_LEN = NUM_REGS * REG_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [AW-1:0]        wr_addr_i,
   input  logic [REG_W-1:0]     wr_data_i,
   output logic [CHAIN_LEN-1:0] img_o
);

   logic [REG_W-1:0] regs_q [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
      end else if (wr_en_i) begin
         for (int r = 0; r < NUM_REGS; r++)
            if (wr_addr_i == AW'(r)) regs_q[r] <= wr_data_i;
      end
   end

   // stream position k maps to img_o[CHAIN_LEN-1-k]
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      for (genvar j = 0; j < REG_W; j++) begin : g_bit
         if (MSB_FIRST) begin : g_msb
            assign img_o[CHAIN_LEN-1-(r*REG_W+j)] = regs_q[r][REG_W-1-j];
         end else begin : g_lsb
            assign img_o[CHAIN_LEN-1-(r*REG_W+j)] = regs_q[r][j];
         end
      end
   end

endmodule

// File: rtl/cfg_shift_engine.sv
module cfg_shift_engine #(
   parameter int CHAIN_LEN = 128,
   parameter int SCLK_DIV  = 4,
   parameter int CW        = $clog2(CHAIN_LEN + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go_i,
   input  logic [CHAIN_LEN-1:0] img_i,
   input  logic                 sdi_i,
   output logic                 run_o,
   output logic                 sclk_o,
   output logic                 sdo_o,
   output logic                 end_o,
   output logic [CW-1:0]        mism_o
);

   localparam int HALF = SCLK_DIV / 2;
   localparam int PW   = cfg_chain_pkg::bits_for(SCLK_DIV);
   localparam int IW   = cfg_chain_pkg::bits_for(CHAIN_LEN);
   localparam logic [PW-1:0] PH_RISE = PW'(HALF - 1);
   localparam logic [PW-1:0] PH_FALL = PW'(SCLK_DIV - 1);
   localparam logic [IW-1:0] LAST    = IW'(CHAIN_LEN - 1);

   logic          run_q, pass2_q, sclk_q, sdo_q;
   logic [PW-1:0] ph_q;
   logic [IW-1:0] idx_q, idx_nx;
   logic [CW-1:0] mism_q;
   logic          at_rise, at_fall, last_bit;

   assign idx_nx   = idx_q + 1'b1;
   assign at_rise  = run_q && (ph_q == PH_RISE);
   assign at_fall  = run_q && (ph_q == PH_FALL);
   assign last_bit = (idx_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         pass2_q <= 1'b0;
         sclk_q  <= 1'b0;
         sdo_q   <= 1'b0;
         ph_q    <= '0;
         idx_q   <= '0;
         mism_q  <= '0;
      end else if (!run_q) begin
         if (go_i) begin
            run_q   <= 1'b1;
            pass2_q <= 1'b0;
            sclk_q  <= 1'b0;
            ph_q    <= '0;
            idx_q   <= '0;
            mism_q  <= '0;
            sdo_q   <= img_i[LAST];
         end
      end else begin
         ph_q <= at_fall ? '0 : ph_q + 1'b1;
         if (at_rise) begin
            sclk_q <= 1'b1;
            if (pass2_q && (sdi_i != sdo_q)) mism_q <= mism_q + 1'b1;
         end
         if (at_fall) begin
            sclk_q <= 1'b0;
            if (last_bit) begin
               idx_q <= '0;
               if (pass2_q) begin
                  run_q <= 1'b0;
                  sdo_q <= 1'b0;
               end else begin
                  pass2_q <= 1'b1;
                  sdo_q   <= img_i[LAST];
               end
            end else begin
               idx_q <= idx_nx;
               sdo_q <= img_i[LAST - idx_nx];
            end
         end
      end
   end

   assign run_o  = run_q;
   assign sclk_o = sclk_q;
   assign sdo_o  = sdo_q;
   assign end_o  = at_fall && last_bit && pass2_q;
   assign mism_o = mism_q;

   // R3: data only moves with a falling serial clock while running
   a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && !$stable(sdo_q)) |-> $fell(sclk_q));

   // R5: nothing is counted during the first pass
   a_r5_first_pass_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !pass2_q) |-> (mism_q == '0));

   // R2: serial clock never runs outside a load
   a_r2_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !sclk_q);

endmodule

// File: rtl/cfg_hold_timer.sv
module cfg_hold_timer #(
   parameter int RST_HOLD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic last_o
);

   localparam int TW = $clog2(RST_HOLD + 1);
   localparam logic [TW-1:0] LIMIT = TW'(RST_HOLD - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (en_i)   cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = en_i && (cnt_q == LIMIT);

   // R8 / R9: the hold counter never passes its limit while a reset action runs
   a_r8_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (cnt_q <= LIMIT));

endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader #(
   parameter int NUM_REGS  = 16,
   parameter int REG_W     = 8,
   parameter int SCLK_DIV  = 4,
   parameter int RST_HOLD  = 8,
   parameter bit MSB_FIRST = 1'b1,
   parameter int AW        = cfg_chain_pkg::bits_for(NUM_REGS),
   parameter int CW        = $clog2(NUM_REGS * REG_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [AW-1:0]    wr_addr_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             start_i,
   input  logic             soft_rst_req_i,
   input  logic             hard_rst_req_i,
   output logic             cs_n_o,
   output logic             sclk_o,
   output logic             sdo_o,
   input  logic             sdi_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic [CW-1:0]    mismatch_o
);
   import cfg_chain_pkg::*;

   localparam int CHAIN_LEN = NUM_REGS * REG_W;

   if (NUM_REGS < 2)                          begin : g_chk_regs $error("NUM_REGS must be 2 or more"); end
   if (REG_W < 1)                             begin : g_chk_w    $error("REG_W must be 1 or more"); end
   if (SCLK_DIV < 2 || (SCLK_DIV % 2) != 0)   begin : g_chk_div  $error("SCLK_DIV must be even and 2 or more"); end
   if (RST_HOLD < 1)                          begin : g_chk_hold $error("RST_HOLD must be 1 or more"); end

   ld_state_t            state_q, state_n;
   logic [CHAIN_LEN-1:0] img;
   logic                 eng_go, eng_run, eng_sclk, eng_sdo, eng_end;
   logic [CW-1:0]        eng_mism;
   logic                 tmr_clr, tmr_en, tmr_last;
   logic                 done_q, err_q, load_fin;

   cfg_image_regs #(
      .NUM_REGS(NUM_REGS), .REG_W(REG_W), .MSB_FIRST(MSB_FIRST),
      .AW(AW), .CHAIN_LEN(CHAIN_LEN)
   ) u_img (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .img_o(img)
   );

   cfg_shift_engine #(
      .CHAIN_LEN(CHAIN_LEN), .SCLK_DIV(SCLK_DIV), .CW(CW)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .go_i(eng_go), .img_i(img), .sdi_i(sdi_i),
      .run_o(eng_run), .sclk_o(eng_sclk), .sdo_o(eng_sdo), .end_o(eng_end),
      .mism_o(eng_mism)
   );

   cfg_hold_timer #(.RST_HOLD(RST_HOLD)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .en_i(tmr_en), .last_o(tmr_last)
   );

   assign tmr_en   = (state_q == ST_SOFT) || (state_q == ST_HARD);
   assign load_fin = (state_q == ST_SHIFT) && eng_end;

   always_comb begin
      state_n = state_q;
      eng_go  = 1'b0;
      tmr_clr = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (hard_rst_req_i) begin
               state_n = ST_HARD;
               tmr_clr = 1'b1;
            end else if (soft_rst_req_i) begin
               state_n = ST_SOFT;
               tmr_clr = 1'b1;
            end else if (start_i) begin
               state_n = ST_SHIFT;
               eng_go  = 1'b1;
            end
         end
         ST_SHIFT: if (eng_end)  state_n = ST_IDLE;
         ST_SOFT,
         ST_HARD:  if (tmr_last) state_n = ST_IDLE;
         default:  state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_n;
         if (eng_go) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end else if (load_fin) begin
            done_q <= 1'b1;
            err_q  <= (eng_mism != '0);
         end
      end
   end

   // pin encoding: shifting and soft reset hold select active
   assign cs_n_o     = !((state_q == ST_SHIFT) || (state_q == ST_SOFT));
   assign sclk_o     = (state_q == ST_SHIFT) ? eng_sclk : (state_q == ST_SOFT);
   assign sdo_o      = (state_q == ST_SHIFT) ? eng_sdo  : (state_q == ST_HARD);
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign err_o      = err_q;
   assign mismatch_o = eng_mism;

   // R2: the chain is selected whenever the engine is shifting
   a_r2_select_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
      eng_run |-> !cs_n_o);

   // R7: the engine only launches from idle
   a_r7_launch_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_run) |-> ($past(state_q) == ST_IDLE));

   // R7: a request during an action does not disturb it
   a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_IDLE) && (start_i || soft_rst_req_i || hard_rst_req_i)
       && !eng_end && !tmr_last) |=> (state_q == $past(state_q)));

   // R10: hard reset wins any idle collision
   a_r10_hard_first: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE) && hard_rst_req_i) |=> (state_q == ST_HARD));

   // R6: the error flag moves only at a start or at load completion
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(eng_go) && !$past(load_fin)) |-> $stable(err_q));

   // R11: idle pins are parked
   a_r11_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && !sclk_o && !sdo_o));

endmodule

// File: tb/sim_cfg_chain_loader.sv
module sim_cfg_chain_loader;

   localparam int N    = 16;
   localparam int W    = 8;
   localparam int DIV  = 4;
   localparam int HOLD = 8;
   localparam int L    = N * W;
   localparam int AW   = $clog2(N);
   localparam int CW   = $clog2(L + 1);

   typedef struct {
      logic         err;
      int           mism;
      logic [L-1:0] img;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic start = 1'b0, soft_req = 1'b0, hard_req = 1'b0;
   logic cs_n, sclk, sdo, sdi, busy, done, err;
   logic [CW-1:0] mism;

   always #5 clk = ~clk;

   cfg_chain_loader #(.NUM_REGS(N), .REG_W(W), .SCLK_DIV(DIV), .RST_HOLD(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .start_i(start), .soft_rst_req_i(soft_req), .hard_rst_req_i(hard_req),
      .cs_n_o(cs_n), .sclk_o(sclk), .sdo_o(sdo), .sdi_i(sdi),
      .busy_o(busy), .done_o(done), .err_o(err), .mismatch_o(mism)
   );

   // external chain model: shifts on rising serial clock while selected
   logic [L-1:0] chain_m = '0;
   int edge_cnt = 0, edge_base = 0, inj_k = 0;
   int low_cnt = 0, low_base = 0;
   int rel;
   always @(posedge sclk) begin
      if (!cs_n) begin
         chain_m  <= {chain_m[L-2:0], sdo};
         edge_cnt <= edge_cnt + 1;
      end
   end
   always @(negedge clk) if (!cs_n) low_cnt <= low_cnt + 1;
   assign rel = edge_cnt - edge_base;
   assign sdi = chain_m[L-1] ^ ((rel >= L) && (rel < L + inj_k));

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [W-1:0] img_m [N];
   exp_t exp_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   task automatic wr(input int a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; img_m[a] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: pushes the expected result, then runs one load
   task automatic run_load(input int k, input int poke_at);
      exp_t e;
      for (int r = 0; r < N; r++)
         for (int b = 0; b < W; b++)
            e.img[L-1-(r*W+(W-1-b))] = img_m[r][b];
      e.mism = k;
      e.err  = (k != 0);
      exp_q.push_back(e);
      inj_k = k;
      @(negedge clk);
      edge_base = edge_cnt;
      low_base  = low_cnt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      chk(done == 1'b0 && err == 1'b0 && mism == '0, "R6 cleared at start", {done, err}, 0);
      if (poke_at > 0) begin
         repeat (poke_at) @(negedge clk);
         start = 1'b1; soft_req = 1'b1; hard_req = 1'b1;
         @(negedge clk);
         start = 1'b0; soft_req = 1'b0; hard_req = 1'b0;
         chk(cs_n == 1'b0 && busy == 1'b1, "R7 load continues", cs_n, 0);
      end
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // monitor: pops on each completion
   logic done_prev = 1'b0;
   always @(negedge clk) begin
      if (done && !done_prev) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected completion", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(err == e.err, "R5 err flag", err, e.err);
            chk(int'(mism) == e.mism, "R5 mismatch count", mism, e.mism);
            chk(chain_m == e.img, "R1 R4 chain image", int'(chain_m != e.img), 0);
            chk(rel == 2 * L, "R2 serial clock edges", rel, 2 * L);
            chk(low_cnt - low_base == 2 * L * DIV, "R2 select low cycles", low_cnt - low_base, 2 * L * DIV);
            chk(cs_n && !sclk && !sdo && !busy, "R11 idle after load", {cs_n, sclk, sdo, busy}, 8);
         end
      end
      done_prev = done;
   end

   // reset action: h/s/st raised together for one cycle
   task automatic rst_action(input bit h, input bit s, input bit st, input string req);
      int hits = 0;
      int e0 = edge_cnt;
      logic d0 = done;
      bit first_ok;
      @(negedge clk);
      hard_req = h; soft_req = s; start = st;
      @(negedge clk);
      hard_req = 1'b0; soft_req = 1'b0; start = 1'b0;
      first_ok = h ? (cs_n && !sclk && sdo) : (!cs_n && sclk && !sdo);
      chk(first_ok, {req, " pattern starts next cycle"}, {cs_n, sclk, sdo}, h ? 5 : 2);
      for (int i = 0; i < HOLD + 4; i++) begin
         if (h ? (cs_n && !sclk && sdo) : (!cs_n && sclk && !sdo)) hits++;
         @(negedge clk);
      end
      chk(hits == HOLD, {req, " hold length"}, hits, HOLD);
      chk(!busy && cs_n && !sclk && !sdo, {req, " back to idle"}, busy, 0);
      chk(edge_cnt - e0 <= 1 && done == d0, {req, " no load started"}, edge_cnt - e0, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n && !sclk && !sdo, "R11 reset pins", {cs_n, sclk, sdo}, 4);
      chk(!busy && !done && !err && mism == '0, "R11 reset status", {busy, done, err}, 0);

      for (int r = 0; r < N; r++) wr(r, W'(8'hA5 ^ (r * 17)));
      run_load(0, 0);

      for (int r = 0; r < N; r++) wr(r, W'(8'h3C + r * 7));
      run_load(5, 0);
      repeat (40) @(negedge clk);
      chk(err == 1'b1 && done == 1'b1, "R6 flags sticky", {done, err}, 3);

      rst_action(1'b0, 1'b1, 1'b0, "R8 soft reset");
      chk(err == 1'b1 && int'(mism) == 5, "R6 flags survive reset", mism, 5);
      rst_action(1'b1, 1'b0, 1'b0, "R9 hard reset");
      rst_action(1'b1, 1'b1, 1'b1, "R10 hard over soft and start");
      rst_action(1'b0, 1'b1, 1'b1, "R10 soft over start");

      for (int r = 0; r < N; r++) wr(r, W'(r * 29 + 3));
      run_load(L, 0);

      run_load(0, 100);
      repeat (20) @(negedge clk);
      chk(!busy && exp_q.size() == 0, "R7 no second load", busy, 0);
      chk(err == 1'b0 && done == 1'b1, "R6 clean load clears error", err, 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule